// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. Bytes for the line enter through a valid/ready stream into a 64-entry transmit queue. A character engine serializes them onto `txd`. A receive engine oversamples `rxd` and places each decoded character, together with its parity-error and stop-error flags, into a 64-entry receive queue. That queue is drained through a second valid/ready stream.

Both streams follow the usual back-pressure rules. A transfer happens on a rising clock edge where valid and ready are both high. `tx_ready` stays low while the transmit queue is full. `rx_valid` stays high, with `rx_data`, `rx_perr` and `rx_ferr` held steady, until the consumer raises `rx_ready`.

Character shape comes from plain configuration pins: data length, parity mode and stop length. These pins must only change while both engines are idle. Bit timing comes from a divisor `cfg_div`. A sub-bit tick fires every `cfg_div+1` clocks, and one bit lasts 16 ticks, so `cfg_div = f_clk/(16*baud) - 1`. For example, 115.2 kbit/s from a 29.4912 MHz clock uses a divisor of 15. The engine starts a new character only while `cts` is high. `rts` tells the far end whether the receive queue still has headroom.

Top module: `serial_port`

## Requirements
- R1: The line idles high. Each character is sent as a low start bit, then the data bits LSB first, then the parity bit if enabled, then high stop bits.
- R2: `cfg_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. A received character appears on `rx_data` zero-extended to 8 bits.
- R3: `cfg_par` selects the parity mode. Code 1 is even (the parity bit makes the count of ones even). Code 2 is odd. Codes 0 and 3 send no parity bit.
- R4: `cfg_stop` selects the stop length. Code 0 is 16 ticks, code 1 is 24 ticks, and codes 2 and 3 are 32 ticks. Characters queued back to back start exactly one frame length apart.
- R5: A tick occurs every `cfg_div+1` clocks, and each start, data and parity bit lasts 16 ticks.
- R6: A character begins only in a tick where `cts` is high. Dropping `cts` mid-character lets that character finish but holds back the next one.
- R7: The receiver confirms a start bit 8 ticks after the falling edge and samples each later bit at its centre. `rx_perr` is 1 when the received parity bit disagrees with the configured mode.
- R8: `rx_ferr` is 1 when the first stop-bit sample is low. After such a character, the receiver waits for the line to return high before it looks for a new start bit.
- R9: A character that completes while the receive queue holds 64 entries is discarded. `err_overrun` pulses high for one clock, and the stored entries are left unchanged.
- R10: Each queue holds 64 entries. `tx_ready` is low exactly when 64 bytes are queued. `rx_valid`, `rx_data` and the flags hold while `rx_ready` is low.
- R11: `rts` is low while the receive queue holds 60 or more entries (depth minus `RTS_MARGIN`) and high otherwise.
- R12: After reset, `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and `rts` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Tick divisor; a tick occurs every cfg_div+1 clocks |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par | input | 2 | Parity code: 1 even, 2 odd, 0/3 none |
| cfg_stop | input | 2 | Stop code: 0 one bit, 1 one and a half, 2/3 two |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| rx_data | output | 8 | Oldest received character |
| rx_perr | output | 1 | Parity error flag of that character |
| rx_ferr | output | 1 | Stop-bit error flag of that character |
| rx_valid | output | 1 | A received character is available |
| rx_ready | input | 1 | Consumer takes the character |
| err_overrun | output | 1 | One-clock pulse when a character was dropped |
| cts | input | 1 | Far end accepts data (high = may send) |
| rts | output | 1 | Receive queue has headroom (high = send) |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |

## Verification
The transmit engine can end a character's final stop tick and launch the next character's start bit in the same tick. The bench provokes this by queuing several bytes before the first frame ends, under every combination of length, parity and stop setting. It judges the result by requiring the falling edges of successive start bits to be exactly the computed frame length apart, in clocks. The second overlap is a character completing while the receive queue is full. There, the bench holds `rx_ready` low through 65 arrivals, then requires exactly one overrun pulse, an intact queue of the first 64 values, and an empty queue afterwards.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef enum logic [2:0] {FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP} frame_st_e;

  // number of data bits for a length code
  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // stop duration in ticks for a stop code
  function automatic logic [5:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic parity_on(input logic [1:0] par);
    return (par == 2'd1) || (par == 2'd2);
  endfunction

  // parity bit over the active data bits; odd mode inverts
  function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] len,
                                      input logic [1:0] par);
    logic [7:0] mask;
    mask = 8'hFF >> (2'd3 - len);
    return (^(d & mask)) ^ (par == 2'd2);
  endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign full    = count == (AW+1)'(DEPTH);
  assign empty   = count == '0;
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic [1:0] cfg_stop,
  input  logic       cts,
  input  logic       fifo_valid,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  output logic       txd
);
  frame_st_e  st;
  logic [5:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] sh;
  logic       pbit;
  logic       bit_end, stop_end, go;

  assign bit_end  = tcnt == 6'd15;
  assign stop_end = (st == FS_STOP) && (tcnt == stop_ticks(cfg_stop) - 6'd1);
  // a new character may begin from idle or straight out of the last stop tick
  assign go       = tick && fifo_valid && cts && ((st == FS_IDLE) || stop_end);
  assign fifo_pop = go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FS_IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      txd  <= 1'b1;
    end else if (go) begin
      st   <= FS_START;
      txd  <= 1'b0;
      tcnt <= '0;
      bidx <= '0;
      sh   <= fifo_data;
      pbit <= parity_bit(fifo_data, cfg_len, cfg_par);
    end else if (tick) begin
      case (st)
        FS_IDLE: txd <= 1'b1;
        FS_START:
          if (bit_end) begin
            tcnt <= '0;
            st   <= FS_DATA;
            txd  <= sh[0];
          end else tcnt <= tcnt + 6'd1;
        FS_DATA:
          if (bit_end) begin
            tcnt <= '0;
            if ({1'b0, bidx} == data_bits(cfg_len) - 4'd1) begin
              if (parity_on(cfg_par)) begin
                st  <= FS_PAR;
                txd <= pbit;
              end else begin
                st  <= FS_STOP;
                txd <= 1'b1;
              end
            end else begin
              bidx <= bidx + 3'd1;
              sh   <= sh >> 1;
              txd  <= sh[1];
            end
          end else tcnt <= tcnt + 6'd1;
        FS_PAR:
          if (bit_end) begin
            tcnt <= '0;
            st   <= FS_STOP;
            txd  <= 1'b1;
          end else tcnt <= tcnt + 6'd1;
        FS_STOP:
          if (stop_end) st <= FS_IDLE;
          else tcnt <= tcnt + 6'd1;
        default: st <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       rxd,
  output logic       push,
  output logic [7:0] push_data,
  output logic       push_perr,
  output logic       push_ferr
);
  frame_st_e  st;
  logic [3:0] cnt;
  logic [2:0] bidx;
  logic [7:0] sh;
  logic       rx_meta, rx_s, line_hi, perr;

  // bits arrive LSB first into the top of sh; realign for short lengths
  assign push_data = sh >> (4'd8 - data_bits(cfg_len));
  assign push_perr = perr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      sh        <= '0;
      perr      <= 1'b0;
      line_hi   <= 1'b0;
      push      <= 1'b0;
      push_ferr <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          FS_IDLE:
            if (rx_s) line_hi <= 1'b1;
            else if (line_hi) begin
              st      <= FS_START;
              cnt     <= '0;
              line_hi <= 1'b0;
            end
          FS_START:
            if (cnt == 4'd7) begin
              cnt  <= '0;
              bidx <= '0;
              perr <= 1'b0;
              st   <= rx_s ? FS_IDLE : FS_DATA;
            end else cnt <= cnt + 4'd1;
          FS_DATA: begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              sh <= {rx_s, sh[7:1]};
              if ({1'b0, bidx} == data_bits(cfg_len) - 4'd1)
                st <= parity_on(cfg_par) ? FS_PAR : FS_STOP;
              else bidx <= bidx + 3'd1;
            end
          end
          FS_PAR: begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              perr <= rx_s != parity_bit(push_data, cfg_len, cfg_par);
              st   <= FS_STOP;
            end
          end
          FS_STOP: begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              push      <= 1'b1;
              push_ferr <= !rx_s;
              st        <= FS_IDLE;
            end
          end
          default: st <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_port.sv
module serial_port #(
  parameter int FIFO_DEPTH = 64,
  parameter int DIV_W      = 16,
  parameter int RTS_MARGIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic [1:0]       cfg_stop,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             err_overrun,
  input  logic             cts,
  output logic             rts,
  output logic             txd,
  input  logic             rxd
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [CW-1:0] RTS_LIMIT = CW'(FIFO_DEPTH - RTS_MARGIN);

  logic [DIV_W-1:0] bcnt;
  logic             tick;
  logic             tx_full, tx_empty, tx_pop;
  logic [7:0]       tx_head;
  logic [CW-1:0]    tx_count, rx_count;
  logic             rx_full, rx_empty;
  logic             rx_push, rx_push_perr, rx_push_ferr;
  logic [7:0]       rx_push_data;

  // tick generator: one pulse every cfg_div+1 clocks
  assign tick = bcnt == '0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? cfg_div : bcnt - 1'b1;
  end

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(tx_valid), .wr_data(tx_data),
    .rd_en(tx_pop), .rd_data(tx_head), .full(tx_full), .empty(tx_empty),
    .count(tx_count));

  serial_tx i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .cts(cts), .fifo_valid(!tx_empty), .fifo_data(tx_head),
    .fifo_pop(tx_pop), .txd(txd));

  serial_rx i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .rxd(rxd), .push(rx_push), .push_data(rx_push_data),
    .push_perr(rx_push_perr), .push_ferr(rx_push_ferr));

  uart_fifo #(.W(10), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(rx_push),
    .wr_data({rx_push_ferr, rx_push_perr, rx_push_data}),
    .rd_en(rx_ready), .rd_data({rx_ferr, rx_perr, rx_data}),
    .full(rx_full), .empty(rx_empty), .count(rx_count));

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;
  assign rts      = rx_count < RTS_LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_overrun <= 1'b0;
    else        err_overrun <= rx_push && rx_full;
  end
endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_pop,
  input logic [CW-1:0] tx_count,
  input logic          txd,
  input logic          cts,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [7:0]    rx_data,
  input logic          rx_perr,
  input logic          rx_ferr,
  input logic [CW-1:0] rx_count,
  input logic          err_overrun,
  input logic          rts
);
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !txd); // R1

  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> cts); // R6

  AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> $past(rx_count) == CW'(DEPTH)); // R9

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_perr)
                              && $stable(rx_ferr)); // R10

  AST_TX_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> tx_count != '0); // R10

  AST_RTS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> $past(rx_valid && rx_ready)); // R11
endmodule

bind serial_port serial_port_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_pop(tx_pop), .tx_count(tx_count), .txd(txd), .cts(cts),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_count(rx_count),
  .err_overrun(err_overrun), .rts(rts));

// File: tb/test_serial_port.sv
module test_serial_port;
  localparam int DIV = 1;
  localparam int TPB = 16 * (DIV + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cfg_div = 16'(DIV);
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd0;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_ready, rx_perr, rx_ferr, rx_valid, rx_ready = 1'b0;
  logic err_overrun, cts = 1'b1, rts, txd, loop = 1'b1, drv_rxd = 1'b1;
  logic rxd_w;
  int tests = 0, fails = 0, cyc = 0, ovr_cnt = 0;
  logic [7:0] exp_b [0:63];

  assign rxd_w = loop ? txd : drv_rxd;

  serial_port i_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .err_overrun(err_overrun), .cts(cts), .rts(rts),
    .txd(txd), .rxd(rxd_w));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (err_overrun) ovr_cnt <= ovr_cnt + 1;
    if (cyc == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int nbits();
    return 5 + int'(cfg_len);
  endfunction

  function automatic logic pbit(input logic [7:0] d);
    logic [7:0] m;
    m = 8'((1 << nbits()) - 1);
    return (^(d & m)) ^ (cfg_par == 2'd2);
  endfunction

  function automatic int frame_clks();
    int st;
    st = (cfg_stop == 2'd0) ? 16 : (cfg_stop == 2'd1) ? 24 : 32;
    return ((1 + nbits() + ((cfg_par == 2'd1 || cfg_par == 2'd2) ? 1 : 0)) * 16 + st)
           * (DIV + 1);
  endfunction

  task automatic push_tx(input logic [7:0] d, output bit acc);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    acc      = tx_ready;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(input logic [7:0] d, input bit pe, input bit fe, input string req);
    @(negedge clk);
    chk(rx_valid, req, int'(rx_valid), 1);
    chk({rx_ferr, rx_perr, rx_data} == {fe, pe, d}, req,
        int'({rx_ferr, rx_perr, rx_data}), int'({fe, pe, d}));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  // independent line decoder: checks R1 bit order, R3 parity, R4/R5 spacing
  task automatic mon_frames(input int base, input int n);
    int tprev = 0;
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (txd) @(negedge clk);
      if (k > 0) chk(cyc - tprev == frame_clks(), "R4 R5 start spacing",
                     cyc - tprev, frame_clks());
      tprev = cyc;
      d = exp_b[base + k];
      repeat (TPB / 2 - 1) @(negedge clk);
      chk(txd == 1'b0, "R1 start bit", int'(txd), 0);
      for (int i = 0; i < nbits(); i++) begin
        repeat (TPB) @(negedge clk);
        chk(txd == d[i], "R1 R2 data bit", int'(txd), int'(d[i]));
      end
      if (cfg_par == 2'd1 || cfg_par == 2'd2) begin
        repeat (TPB) @(negedge clk);
        chk(txd == pbit(d), "R3 parity bit", int'(txd), int'(pbit(d)));
      end
      repeat (TPB) @(negedge clk);
      chk(txd == 1'b1, "R1 stop bit", int'(txd), 1);
    end
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit pflip, input bit stopv);
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (TPB) @(negedge clk);
    for (int i = 0; i < nbits(); i++) begin
      drv_rxd = d[i];
      repeat (TPB) @(negedge clk);
    end
    if (cfg_par == 2'd1 || cfg_par == 2'd2) begin
      drv_rxd = pbit(d) ^ pflip;
      repeat (TPB) @(negedge clk);
    end
    drv_rxd = stopv;
    repeat (TPB) @(negedge clk);
    drv_rxd = 1'b1;
  endtask

  initial begin
    bit acc;
    logic [7:0] m;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(txd == 1'b1, "R12 txd idle", int'(txd), 1);
    chk(tx_ready == 1'b1, "R12 tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R12 rx_valid", int'(rx_valid), 0);
    chk(rts == 1'b1, "R12 rts", int'(rts), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // sweep every length, parity and stop code; three characters back to back
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 3; s++) begin
          cfg_len = 2'(l); cfg_par = 2'(p); cfg_stop = 2'(s);
          exp_b[0] = 8'hA5 ^ 8'((l * 9 + p * 3 + s) * 37);
          exp_b[1] = ~exp_b[0];
          exp_b[2] = 8'((l * 9 + p * 3 + s) * 7 + 1);
          fork
            mon_frames(0, 3);
            for (int k = 0; k < 3; k++) begin
              push_tx(exp_b[k], acc);
              chk(acc, "R10 tx accept", int'(acc), 1);
            end
          join
          repeat (3 * TPB) @(negedge clk);
          m = 8'((1 << nbits()) - 1);
          for (int k = 0; k < 3; k++) pop_rx(exp_b[k] & m, 1'b0, 1'b0, "R2 R7 loopback");
        end

    // all 5-bit values, even parity, one stop
    cfg_len = 2'd0; cfg_par = 2'd1; cfg_stop = 2'd0;
    for (int i = 0; i < 32; i++) exp_b[i] = 8'(i);
    fork
      mon_frames(0, 32);
      for (int k = 0; k < 32; k++) push_tx(exp_b[k], acc);
    join
    repeat (2 * TPB) @(negedge clk);
    for (int k = 0; k < 32; k++) pop_rx(8'(k), 1'b0, 1'b0, "R2 R3 5-bit sweep");

    // R6 flow control
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd0;
    cts = 1'b0;
    exp_b[0] = 8'h3C;
    push_tx(8'h3C, acc);
    acc = 1'b1;
    repeat (5 * TPB) begin
      @(negedge clk);
      if (!txd) acc = 1'b0;
    end
    chk(acc, "R6 held while cts low", int'(acc), 1);
    cts = 1'b1;
    mon_frames(0, 1);
    exp_b[1] = 8'h96; exp_b[2] = 8'h69;
    push_tx(8'h96, acc);
    push_tx(8'h69, acc);
    fork
      mon_frames(1, 1);
      begin
        @(negedge clk);
        while (txd) @(negedge clk);
        repeat (TPB) @(negedge clk);
        cts = 1'b0;
      end
    join
    acc = 1'b1;
    repeat (4 * TPB) begin
      @(negedge clk);
      if (!txd) acc = 1'b0;
    end
    chk(acc, "R6 next char held at boundary", int'(acc), 1);
    cts = 1'b1;
    mon_frames(2, 1);
    repeat (2 * TPB) @(negedge clk);
    for (int k = 0; k < 3; k++) pop_rx(exp_b[k], 1'b0, 1'b0, "R6 delivered");

    // R7/R8 receive errors, 8 bits even parity
    loop = 1'b0; cfg_par = 2'd1;
    drive_frame(8'h5A, 1'b1, 1'b1);
    repeat (8) @(negedge clk);
    pop_rx(8'h5A, 1'b1, 1'b0, "R7 parity error");
    drive_frame(8'h81, 1'b0, 1'b0);
    repeat (2 * TPB) @(negedge clk);
    pop_rx(8'h81, 1'b0, 1'b1, "R8 stop error");
    drive_frame(8'h7E, 1'b0, 1'b1);
    repeat (8) @(negedge clk);
    pop_rx(8'h7E, 1'b0, 1'b0, "R8 recovery");
    @(negedge clk);
    chk(rx_valid == 1'b0, "R8 no spurious char", int'(rx_valid), 0);

    // R10 transmit queue depth
    loop = 1'b1; cfg_par = 2'd0; cts = 1'b0;
    for (int k = 0; k < 64; k++) begin
      exp_b[k] = 8'(k * 3 + 5);
      push_tx(exp_b[k], acc);
      chk(acc, "R10 tx slot free", int'(acc), 1);
    end
    push_tx(8'hEE, acc);
    chk(!acc, "R10 tx_ready low when full", int'(acc), 0);
    cts = 1'b1;
    mon_frames(0, 64);
    repeat (2 * TPB) @(negedge clk);
    chk(ovr_cnt == 0, "R9 no false overrun", ovr_cnt, 0);
    for (int k = 0; k < 64; k++) pop_rx(exp_b[k], 1'b0, 1'b0, "R10 tx depth data");

    // R9/R11 receive queue fill and overrun
    loop = 1'b0;
    for (int k = 0; k < 59; k++) drive_frame(8'(k), 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(rts == 1'b1, "R11 rts high at 59", int'(rts), 1);
    drive_frame(8'd59, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(rts == 1'b0, "R11 rts low at 60", int'(rts), 0);
    for (int k = 60; k < 64; k++) drive_frame(8'(k), 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(ovr_cnt == 0, "R9 full but no overrun yet", ovr_cnt, 0);
    drive_frame(8'hEE, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(ovr_cnt == 1, "R9 one overrun pulse", ovr_cnt, 1);
    for (int k = 0; k < 64; k++) begin
      pop_rx(8'(k), 1'b0, 1'b0, "R9 R10 stored data");
      if (k == 4) begin
        @(negedge clk);
        chk(rts == 1'b1, "R11 rts back high at 59", int'(rts), 1);
      end
    end
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9 dropped char absent", int'(rx_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule